// File: doc/BRIEF.md
# Write-Through Cache with Per-Word Valid Bits

This block is a direct-mapped data cache that sits between a processor port and a word-wide memory port. Each line carries a single address tag, but validity is tracked for every word in the line separately. A read that misses fetches just the one word that was asked for and marks only that word valid. Lines are therefore never filled as a whole, and a miss costs one memory read.

Every write is passed straight through to memory. Memory is therefore always current, and a write can allocate into the cache without reading anything first. The written word is always stored and marked valid. If the line held a different tag, the line takes the new tag and all of its other words are marked invalid. The processor side accepts one request at a time and answers each with a one-cycle response that carries the read data and a flag telling whether the access hit.

Top module: `cwt_cache`

## Requirements
- R1: After reset every word of every line is invalid, so the first read of any address is reported as a miss (`rsp_hit`=0) and causes a memory read; `cpu_ready` is 1 and `rsp_valid`, `mem_rd_req` and `mem_wr_req` are 0.
- R2: A read hits only when the line tag equals the address tag and the addressed word is valid. A hit returns the cached word with `rsp_hit`=1 and performs no memory read.
- R3: A read miss raises `mem_rd_req` with `mem_addr` equal to the request address until `mem_rd_valid`. It returns that word with `rsp_hit`=0 and marks only that word valid, so a neighbouring word that was invalid still misses.
- R4: A read miss whose tag differs from the line tag retags the line and invalidates every other word in it.
- R5: A write whose tag matches and whose word is valid overwrites the word, and the word stays valid; a later read hits with the new data.
- R6: A write whose tag matches and whose word is invalid stores the data and makes the word valid, leaving the other words' validity unchanged.
- R7: A write whose tag differs retags the line, stores the data, marks the written word valid and every other word in the line invalid. No memory read is made.
- R8: Every write raises `mem_wr_req` with the word address and data, held stable until `mem_wr_ack`. `mem_rd_req` stays 0 for the whole write.
- R9: For a write, `rsp_hit` reports whether the tag matched and the word was valid before the write.
- R10: Each accepted request (`req_valid` while `cpu_ready`) yields exactly one single-cycle `rsp_valid` pulse. `cpu_ready` is 0 while a memory access is in progress.
- R11: A read hit responds in the cycle after it is accepted, and back-to-back hits need no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address {tag, line, word} |
| req_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Request accepted this cycle if valid |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Access hit the cache |
| rsp_rdata | output | DATA_W | Read data (write data echoed for writes) |
| mem_rd_req | output | 1 | Single-word memory read request |
| mem_wr_req | output | 1 | Write-through request |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rd_valid | input | 1 | Memory read data valid |
| mem_rd_data | input | DATA_W | Memory read data |
| mem_wr_ack | input | 1 | Memory accepted the write |

## Verification
The assertions check on every cycle the handshake properties. Memory requests hold their address and data until answered. A write never raises a read. The processor port is busy during any memory access. A lookup hit answers in the next cycle with the cached word, and a fill answers with the returned memory word as a miss. The allocation rules cannot be seen in any single cycle, because they show up only in later accesses. These are retagging, the invalidation of sibling words, and the setting of a valid bit without a fill. The bench shows them by sweeping every line through all three write cases, then reading both the written words and the invalidated words. It also runs a long pseudo-random mix over a few tags, checking each outcome against a shadow tag/valid model and a reference memory.

// File: rtl/cwt_pkg.sv
package cwt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RDFILL = 2'd1,
        ST_WRTHRU = 2'd2
    } cwt_state_e;

endpackage

// File: rtl/cwt_tag_store.sv
module cwt_tag_store #(
    parameter int LINES = 16,
    parameter int WORDS = 4,
    parameter int TAG_W = 6,
    localparam int IDX_W = $clog2(LINES),
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic [OFF_W-1:0] lk_word,
    output logic             lk_hit,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [TAG_W-1:0] upd_tag,
    input  logic [OFF_W-1:0] upd_word
);

    logic [LINES-1:0][TAG_W-1:0] tag_d, tag_q;
    logic [LINES-1:0][WORDS-1:0] val_d, val_q;

    // Lookup: tag equality and the addressed word's valid bit
    always_comb begin
        lk_hit = (tag_q[lk_idx] == lk_tag) && val_q[lk_idx][lk_word];
    end

    // Allocation: a tag change keeps only the written word valid,
    // a matching tag just turns the written word on
    always_comb begin
        tag_d = tag_q;
        val_d = val_q;
        if (upd_en) begin
            if (tag_q[upd_idx] != upd_tag) begin
                tag_d[upd_idx] = upd_tag;
                val_d[upd_idx] = '0;
            end
            val_d[upd_idx][upd_word] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_q <= '0;
            val_q <= '0;
        end else begin
            tag_q <= tag_d;
            val_q <= val_d;
        end
    end

endmodule

// File: rtl/cwt_data_store.sv
module cwt_data_store #(
    parameter int LINES  = 16,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(LINES),
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [OFF_W-1:0]  rd_word,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [OFF_W-1:0]  wr_word,
    input  logic [DATA_W-1:0] wr_data
);

    logic [LINES-1:0][WORDS-1:0][DATA_W-1:0] arr_d, arr_q;

    always_comb begin
        rd_data = arr_q[rd_idx][rd_word];
    end

    always_comb begin
        arr_d = arr_q;
        if (wr_en) begin
            arr_d[wr_idx][wr_word] = wr_data;
        end
    end

    // Data words carry no reset: validity lives in the tag store
    always_ff @(posedge clk) begin
        arr_q <= arr_d;
    end

endmodule

// File: rtl/cwt_ctrl.sv
module cwt_ctrl
    import cwt_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              cpu_ready,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              lk_hit,
    input  logic [DATA_W-1:0] lk_data,
    output logic              upd_en,
    output logic [ADDR_W-1:0] upd_addr,
    output logic [DATA_W-1:0] upd_data,
    output logic              mem_rd_req,
    output logic              mem_wr_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rd_valid,
    input  logic [DATA_W-1:0] mem_rd_data,
    input  logic              mem_wr_ack
);

    typedef struct packed {
        cwt_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              hit;
        logic              rsp_v;
        logic [DATA_W-1:0] rdata;
    } ctl_s;

    ctl_s ctl_d, ctl_q;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.rsp_v = 1'b0;
        upd_en      = 1'b0;
        upd_addr    = ctl_q.addr;
        upd_data    = mem_rd_data;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.addr  = req_addr;
                    ctl_d.wdata = req_wdata;
                    ctl_d.hit   = lk_hit;
                    if (req_write) begin
                        // allocate at once, no fill needed
                        upd_en   = 1'b1;
                        upd_addr = req_addr;
                        upd_data = req_wdata;
                        ctl_d.st = ST_WRTHRU;
                    end else if (lk_hit) begin
                        ctl_d.rsp_v = 1'b1;
                        ctl_d.rdata = lk_data;
                    end else begin
                        ctl_d.st = ST_RDFILL;
                    end
                end
            end
            ST_RDFILL: begin
                if (mem_rd_valid) begin
                    upd_en      = 1'b1;
                    ctl_d.rsp_v = 1'b1;
                    ctl_d.rdata = mem_rd_data;
                    ctl_d.hit   = 1'b0;
                    ctl_d.st    = ST_IDLE;
                end
            end
            ST_WRTHRU: begin
                if (mem_wr_ack) begin
                    ctl_d.rsp_v = 1'b1;
                    ctl_d.rdata = ctl_q.wdata;
                    ctl_d.st    = ST_IDLE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cpu_ready  = (ctl_q.st == ST_IDLE);
    assign rsp_valid  = ctl_q.rsp_v;
    assign rsp_hit    = ctl_q.hit;
    assign rsp_rdata  = ctl_q.rdata;
    assign mem_rd_req = (ctl_q.st == ST_RDFILL);
    assign mem_wr_req = (ctl_q.st == ST_WRTHRU);
    assign mem_addr   = ctl_q.addr;
    assign mem_wdata  = ctl_q.wdata;

endmodule

// File: rtl/cwt_cache.sv
module cwt_cache #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int LINES  = 16,
    parameter int WORDS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              cpu_ready,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_rd_req,
    output logic              mem_wr_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rd_valid,
    input  logic [DATA_W-1:0] mem_rd_data,
    input  logic              mem_wr_ack
);

    localparam int OFF_W = $clog2(WORDS);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

    logic              lk_hit;
    logic [DATA_W-1:0] lk_data;
    logic              upd_en;
    logic [ADDR_W-1:0] upd_addr;
    logic [DATA_W-1:0] upd_data;

    // address split: {tag, line index, word offset}
    logic [OFF_W-1:0] lk_word, upd_word;
    logic [IDX_W-1:0] lk_idx, upd_idx;
    logic [TAG_W-1:0] lk_tag, upd_tag;

    assign lk_word  = req_addr[OFF_W-1:0];
    assign lk_idx   = req_addr[OFF_W+IDX_W-1:OFF_W];
    assign lk_tag   = req_addr[ADDR_W-1:OFF_W+IDX_W];
    assign upd_word = upd_addr[OFF_W-1:0];
    assign upd_idx  = upd_addr[OFF_W+IDX_W-1:OFF_W];
    assign upd_tag  = upd_addr[ADDR_W-1:OFF_W+IDX_W];

    cwt_tag_store #(.LINES(LINES), .WORDS(WORDS), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_idx   (lk_idx),
        .lk_tag   (lk_tag),
        .lk_word  (lk_word),
        .lk_hit   (lk_hit),
        .upd_en   (upd_en),
        .upd_idx  (upd_idx),
        .upd_tag  (upd_tag),
        .upd_word (upd_word)
    );

    cwt_data_store #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .rd_idx  (lk_idx),
        .rd_word (lk_word),
        .rd_data (lk_data),
        .wr_en   (upd_en),
        .wr_idx  (upd_idx),
        .wr_word (upd_word),
        .wr_data (upd_data)
    );

    cwt_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .cpu_ready    (cpu_ready),
        .rsp_valid    (rsp_valid),
        .rsp_hit      (rsp_hit),
        .rsp_rdata    (rsp_rdata),
        .lk_hit       (lk_hit),
        .lk_data      (lk_data),
        .upd_en       (upd_en),
        .upd_addr     (upd_addr),
        .upd_data     (upd_data),
        .mem_rd_req   (mem_rd_req),
        .mem_wr_req   (mem_wr_req),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data),
        .mem_wr_ack   (mem_wr_ack)
    );

endmodule

// File: rtl/cwt_cache_chk.sv
module cwt_cache_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic              cpu_ready,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              mem_rd_req,
    input logic              mem_wr_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_rd_valid,
    input logic [DATA_W-1:0] mem_rd_data,
    input logic              mem_wr_ack,
    input logic              lk_hit,
    input logic [DATA_W-1:0] lk_data
);

    AST_WR_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req |-> !mem_rd_req); // R8

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && !mem_wr_ack) |=>
            (mem_wr_req && $stable(mem_addr) && $stable(mem_wdata))); // R8

    AST_WR_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && req_valid && req_write) |=> (mem_wr_req && !rsp_valid)); // R8

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_addr))); // R3

    AST_FILL_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && mem_rd_valid) |=>
            (rsp_valid && !rsp_hit && rsp_rdata == $past(mem_rd_data))); // R3

    AST_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req || mem_wr_req) |-> !cpu_ready); // R10

    AST_HIT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && req_valid && !req_write && lk_hit) |=>
            (rsp_valid && rsp_hit && rsp_rdata == $past(lk_data) && cpu_ready)); // R11

    AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && req_valid && !req_write && lk_hit) |=> !mem_rd_req); // R2

endmodule

bind cwt_cache cwt_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .cpu_ready    (cpu_ready),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_rdata    (rsp_rdata),
    .mem_rd_req   (mem_rd_req),
    .mem_wr_req   (mem_wr_req),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_data  (mem_rd_data),
    .mem_wr_ack   (mem_wr_ack),
    .lk_hit       (lk_hit),
    .lk_data      (lk_data)
);

// File: tb/tb_cwt_cache.sv
`timescale 1ns/1ps
module tb_cwt_cache;

    localparam int AW = 12;
    localparam int DW = 32;
    localparam int NL = 16;
    localparam int NW = 4;
    localparam int MEMSZ = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          cpu_ready, rsp_valid, rsp_hit;
    logic [DW-1:0] rsp_rdata;
    logic          mem_rd_req, mem_wr_req;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_rd_valid;
    logic [DW-1:0] mem_rd_data;
    logic          mem_wr_ack;

    always #4 clk = ~clk;

    cwt_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL), .WORDS(NW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .cpu_ready(cpu_ready),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
        .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .mem_wr_ack(mem_wr_ack)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int rd_count = 0;
    int wr_count = 0;

    logic [DW-1:0] backing [MEMSZ];   // memory behind the cache
    logic [DW-1:0] ref_mem [MEMSZ];   // expected contents
    logic [5:0]    sh_tag [NL];
    logic [NW-1:0] sh_val [NL];

    function automatic logic [DW-1:0] seed_word(int a);
        return (a * 32'h9E3779B1) ^ 32'h5A5A0000;
    endfunction

    function automatic logic [AW-1:0] mk(int t, int i, int w);
        return AW'((t << 6) | (i << 2) | w);
    endfunction

    task automatic chk(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory model: read data after two cycles, write ack after one
    initial begin
        int rd_wait;
        rd_wait = 0;
        mem_rd_valid = 1'b0;
        mem_rd_data = '0;
        mem_wr_ack = 1'b0;
        for (int a = 0; a < MEMSZ; a++) backing[a] = seed_word(a);
        forever begin
            @(negedge clk);
            mem_rd_valid = 1'b0;
            mem_wr_ack = 1'b0;
            if (mem_rd_req) begin
                rd_wait++;
                if (rd_wait == 2) begin
                    mem_rd_valid = 1'b1;
                    mem_rd_data = backing[mem_addr];
                    rd_count++;
                    rd_wait = 0;
                end
            end else begin
                rd_wait = 0;
            end
            if (mem_wr_req) begin
                mem_wr_ack = 1'b1;
                backing[mem_addr] = mem_wdata;
                wr_count++;
            end
        end
    end

    // one request, checked against the shadow model
    task automatic access(bit wr, int t, int i, int w, logic [DW-1:0] d);
        logic [AW-1:0] a;
        bit exp_hit, tag_eq;
        int rd0, wr0, lat;
        string tg;
        a = mk(t, i, w);
        tag_eq = (sh_tag[i] == 6'(t));
        exp_hit = tag_eq && sh_val[i][w];
        rd0 = rd_count;
        wr0 = wr_count;
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        if (wr) tg = exp_hit ? "R5" : (tag_eq ? "R6" : "R7");
        else    tg = exp_hit ? "R2" : (tag_eq ? "R3" : "R4");
        chk(rsp_valid, "R10", "response strobe", 32'(rsp_valid), 1);
        chk(rsp_hit == exp_hit, wr ? "R9" : tg, "hit flag", 32'(rsp_hit), 32'(exp_hit));
        if (!wr) begin
            chk(rsp_rdata == ref_mem[a], tg, "read data", rsp_rdata, ref_mem[a]);
            chk(rd_count - rd0 == (exp_hit ? 0 : 1), tg, "memory reads",
                32'(rd_count - rd0), exp_hit ? 0 : 1);
            if (exp_hit) chk(lat == 1, "R11", "hit latency", 32'(lat), 1);
        end else begin
            ref_mem[a] = d;
            chk(rd_count == rd0, "R8", "reads during write", 32'(rd_count - rd0), 0);
            chk(wr_count - wr0 == 1 && backing[a] == d, "R8", "write-through data", backing[a], d);
        end
        // shadow allocation rules
        if (!tag_eq) begin
            sh_tag[i] = 6'(t);
            sh_val[i] = '0;
        end
        sh_val[i][w] = 1'b1;
        @(negedge clk);
        chk(!rsp_valid, "R10", "single-cycle strobe", 32'(rsp_valid), 0);
    endtask

    initial begin
        logic [15:0] lfsr;
        for (int a = 0; a < MEMSZ; a++) ref_mem[a] = seed_word(a);
        for (int i = 0; i < NL; i++) begin sh_tag[i] = '0; sh_val[i] = '0; end
        repeat (3) @(negedge clk);
        // R1: idle state during and right after reset
        chk(cpu_ready && !rsp_valid && !mem_rd_req && !mem_wr_req, "R1", "reset outputs",
            {cpu_ready, rsp_valid, mem_rd_req, mem_wr_req}, 32'h8);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cpu_ready && !rsp_valid, "R1", "after reset", {cpu_ready, rsp_valid}, 32'h2);

        // R1/R3: first touch misses, fills one word; neighbour still misses
        for (int i = 0; i < NL; i++) begin
            access(0, 0, i, 0, '0);
            access(0, 0, i, 0, '0);
            access(0, 0, i, 1, '0);
        end
        // R5/R6/R7/R4 per line
        for (int i = 0; i < NL; i++) begin
            access(1, 0, i, 0, 32'hA000_0000 + i);
            access(1, 0, i, 2, 32'hB000_0000 + i);
            access(0, 0, i, 2, '0);
            access(0, 0, i, 1, '0);
            access(1, 5, i, 1, 32'hC000_0000 + i);
            access(0, 5, i, 0, '0);
            access(0, 5, i, 1, '0);
            access(0, 0, i, 2, '0);
            access(0, 5, i, 1, '0);
        end
        // pseudo-random mix over four tags
        lfsr = 16'hACE1;
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            access(lfsr[0] & lfsr[7], int'(lfsr[9:8]), int'(lfsr[13:10]), int'(lfsr[15:14]),
                   {lfsr, ~lfsr});
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule